// File: doc/BRIEF.md
# Paged Address Translation Unit

This block maps a 16-bit logical address to a physical address through a page table held inside the block. The upper bits of the logical address select a virtual page and the lower bits pass through unchanged as the word offset. The table is indexed by the virtual machine number and the virtual page number together. As a result, every virtual machine has its own private set of pages, including its own page 0. Each entry keeps a resident flag, a modified (dirty) flag and a physical page number.

Requests arrive on a valid/ready stream. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The result appears on a registered response stream one cycle later. The result is either a physical address or a page-fault indication, and `irq_fault` follows a faulting response. The response is held unchanged while `rsp_ready` is low. During that time `req_ready` is low, so an upstream source must keep its request steady until it is accepted.

Software keeps the table up to date through a plain maintenance port, which can install or evict one entry per cycle. It checks the dirty flag of an entry through a combinational readback port before evicting it. When a store hits a resident page, the hardware sets that page's dirty flag.

Top module: `pmu_xlate`

## Requirements
- R1: Address split and index. The virtual page number is `req_addr[15:8]` and the offset is `req_addr[7:0]`. The table index is `{req_vm, vpn}`, and the physical address is `{ppn, offset}`.
- R2: A request accepted on edge N whose entry is resident gives `rsp_valid=1`, `rsp_fault=0` and `rsp_paddr={ppn, offset}` after edge N.
- R3: A request whose entry is not resident gives `rsp_valid=1`, `rsp_fault=1`, `irq_fault=1` and `rsp_paddr=0`. A faulting access, whether a read or a store, changes no table state.
- R4: A store (`req_store=1`) accepted to a resident entry sets that entry's dirty flag to 1.
- R5: `mnt_op=2'b01` (install) writes `mnt_ppn` into the entry at `{mnt_vm, mnt_vpn}`, sets the resident flag and clears the dirty flag.
- R6: `mnt_op=2'b10` (evict) clears the resident flag of the entry and leaves its dirty flag and page number readable. Later accesses to that entry fault. The codes `2'b00` and `2'b11` do nothing.
- R7: A read access (`req_store=0`) never changes the dirty flag.
- R8: While `rsp_valid=1` and `rsp_ready=0`, the response outputs hold steady and `req_ready=0`. At all other times `req_ready=1`, so a new request may be accepted on the same edge that consumes the old response.
- R9: The same virtual page number under different VM numbers selects independent entries.
- R10: After reset, every entry is non-resident with dirty flag 0, `rsp_valid=0` and `req_ready=1`.
- R11: If a maintenance write and an accepted request target the same entry on the same edge, the request sees the old contents and the maintenance result is what the entry holds afterwards. For example, an install clears dirty even when a store hits on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request may be accepted |
| req_addr | input | 16 | Logical address |
| req_vm | input | 2 | Virtual machine number |
| req_store | input | 1 | 1 = store access, 0 = read access |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 16 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Response is a page fault |
| irq_fault | output | 1 | Page-fault interrupt, high while a faulting response is presented |
| mnt_op | input | 2 | 01 install, 10 evict, others no operation |
| mnt_vm | input | 2 | VM number of the maintained entry |
| mnt_vpn | input | 8 | Virtual page of the maintained entry |
| mnt_ppn | input | 8 | Physical page written on install |
| rb_vm | input | 2 | VM number of the entry to read back |
| rb_vpn | input | 8 | Virtual page of the entry to read back |
| rb_resident | output | 1 | Resident flag of the selected entry |
| rb_dirty | output | 1 | Dirty flag of the selected entry |
| rb_ppn | output | 8 | Physical page of the selected entry |

## Verification
The back-pressure assertion assumes that the consumer only lowers `rsp_ready` as part of a clean handshake. The table assertions assume that the maintenance code and index are steady across the edge where they take effect. The stimulus meets both conditions because it changes every input only on the falling edge. It also drops `mnt_op` back to no operation after exactly one rising edge, so each install or evict applies once. The store-versus-read dirty assertions expect that a maintenance write to the looked-up entry may override the lookup on the same edge, and they exclude that case. The bench also exercises that collision on purpose.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  typedef enum logic [1:0] {
    MNT_NONE    = 2'b00,
    MNT_INSTALL = 2'b01,
    MNT_EVICT   = 2'b10,
    MNT_RSVD    = 2'b11
  } mnt_op_e;
endpackage

// File: rtl/pmu_maint.sv
module pmu_maint #(
  parameter int VM_W  = 2,
  parameter int VPN_W = 8,
  localparam int IDX_W = VM_W + VPN_W
) (
  input  logic [1:0]       op,
  input  logic [VM_W-1:0]  vm,
  input  logic [VPN_W-1:0] vpn,
  output logic             install,
  output logic             evict,
  output logic [IDX_W-1:0] idx
);
  import pmu_pkg::*;

  always_comb begin
    install = 1'b0;
    evict   = 1'b0;
    unique case (mnt_op_e'(op))
      MNT_INSTALL: install = 1'b1;
      MNT_EVICT:   evict   = 1'b1;
      default: ;
    endcase
    idx = {vm, vpn};
  end
endmodule

// File: rtl/pmu_table.sv
module pmu_table #(
  parameter int IDX_W = 10,
  parameter int PPN_W = 8,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_en,
  input  logic             lk_store,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_res,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             mnt_install,
  input  logic             mnt_evict,
  input  logic [IDX_W-1:0] mnt_idx,
  input  logic [PPN_W-1:0] mnt_ppn,
  input  logic [IDX_W-1:0] rb_idx,
  output logic             rb_res,
  output logic             rb_dirty,
  output logic [PPN_W-1:0] rb_ppn
);
  logic             res_q   [ENTRIES];
  logic             dirty_q [ENTRIES];
  logic [PPN_W-1:0] ppn_q   [ENTRIES];
  logic             set_dirty;
  logic             mnt_any;
  logic             mnt_same;

  assign lk_res    = res_q[lk_idx];
  assign lk_ppn    = ppn_q[lk_idx];
  assign rb_res    = res_q[rb_idx];
  assign rb_dirty  = dirty_q[rb_idx];
  assign rb_ppn    = ppn_q[rb_idx];
  assign set_dirty = lk_en && lk_store && lk_res;
  assign mnt_any   = mnt_install || mnt_evict;
  assign mnt_same  = mnt_any && (mnt_idx == lk_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) res_q[i] <= 1'b0;
    end else if (mnt_install) begin
      res_q[mnt_idx] <= 1'b1;
    end else if (mnt_evict) begin
      res_q[mnt_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) dirty_q[i] <= 1'b0;
    end else begin
      if (set_dirty)   dirty_q[lk_idx]  <= 1'b1;
      if (mnt_install) dirty_q[mnt_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (mnt_install) ppn_q[mnt_idx] <= mnt_ppn;
  end

  assert_install_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mnt_install |=> (res_q[$past(mnt_idx)] && !dirty_q[$past(mnt_idx)]));

  assert_evict_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mnt_evict |=> !res_q[$past(mnt_idx)]);

  assert_store_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && lk_store && lk_res && !mnt_same) |=> dirty_q[$past(lk_idx)]);

  assert_read_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && !lk_store && !mnt_same) |=>
      (dirty_q[$past(lk_idx)] == $past(dirty_q[lk_idx])));

  assert_fault_no_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && !lk_res && !mnt_same) |=>
      (!res_q[$past(lk_idx)] && (dirty_q[$past(lk_idx)] == $past(dirty_q[lk_idx]))));
endmodule

// File: rtl/pmu_resp.sv
module pmu_resp #(
  parameter int PPN_W = 8,
  parameter int OFF_W = 8,
  localparam int PA_W = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             hit,
  input  logic [PPN_W-1:0] ppn,
  input  logic [OFF_W-1:0] offset,
  output logic             accept,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault
);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_fault <= !hit;
      rsp_paddr <= hit ? {ppn, offset} : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  assert_fault_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> (rsp_fault && rsp_paddr == '0));
endmodule

// File: rtl/pmu_xlate.sv
module pmu_xlate #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8,
  parameter int PPN_W  = 8,
  parameter int VM_W   = 2,
  localparam int VPN_W = ADDR_W - OFF_W,
  localparam int IDX_W = VM_W + VPN_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [VM_W-1:0]   req_vm,
  input  logic              req_store,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_fault,
  output logic              irq_fault,
  input  logic [1:0]        mnt_op,
  input  logic [VM_W-1:0]   mnt_vm,
  input  logic [VPN_W-1:0]  mnt_vpn,
  input  logic [PPN_W-1:0]  mnt_ppn,
  input  logic [VM_W-1:0]   rb_vm,
  input  logic [VPN_W-1:0]  rb_vpn,
  output logic              rb_resident,
  output logic              rb_dirty,
  output logic [PPN_W-1:0]  rb_ppn
);
  logic [VPN_W-1:0] vpn;
  logic [OFF_W-1:0] offset;
  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] mnt_idx;
  logic [IDX_W-1:0] rb_idx;
  logic             mnt_install;
  logic             mnt_evict;
  logic             lk_res;
  logic [PPN_W-1:0] lk_ppn;
  logic             accept;

  assign vpn    = req_addr[ADDR_W-1:OFF_W];
  assign offset = req_addr[OFF_W-1:0];
  assign lk_idx = {req_vm, vpn};
  assign rb_idx = {rb_vm, rb_vpn};

  pmu_maint #(.VM_W(VM_W), .VPN_W(VPN_W)) u_maint (
    .op(mnt_op), .vm(mnt_vm), .vpn(mnt_vpn),
    .install(mnt_install), .evict(mnt_evict), .idx(mnt_idx)
  );

  pmu_table #(.IDX_W(IDX_W), .PPN_W(PPN_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .lk_en(accept), .lk_store(req_store), .lk_idx(lk_idx),
    .lk_res(lk_res), .lk_ppn(lk_ppn),
    .mnt_install(mnt_install), .mnt_evict(mnt_evict),
    .mnt_idx(mnt_idx), .mnt_ppn(mnt_ppn),
    .rb_idx(rb_idx), .rb_res(rb_resident), .rb_dirty(rb_dirty), .rb_ppn(rb_ppn)
  );

  pmu_resp #(.PPN_W(PPN_W), .OFF_W(OFF_W)) u_resp (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .hit(lk_res), .ppn(lk_ppn), .offset(offset), .accept(accept),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  assign irq_fault = rsp_valid && rsp_fault;

  assert_irq_pairs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !lk_res) |=> irq_fault);

  assert_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

// File: tb/sim_pmu_xlate.sv
module sim_pmu_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_vm = '0;
  logic        req_store = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_paddr;
  logic        rsp_fault;
  logic        irq_fault;
  logic [1:0]  mnt_op = 2'b00;
  logic [1:0]  mnt_vm = '0;
  logic [7:0]  mnt_vpn = '0;
  logic [7:0]  mnt_ppn = '0;
  logic [1:0]  rb_vm = '0;
  logic [7:0]  rb_vpn = '0;
  logic        rb_resident;
  logic        rb_dirty;
  logic [7:0]  rb_ppn;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pmu_xlate u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_vm(req_vm), .req_store(req_store),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .irq_fault(irq_fault),
    .mnt_op(mnt_op), .mnt_vm(mnt_vm), .mnt_vpn(mnt_vpn), .mnt_ppn(mnt_ppn),
    .rb_vm(rb_vm), .rb_vpn(rb_vpn),
    .rb_resident(rb_resident), .rb_dirty(rb_dirty), .rb_ppn(rb_ppn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mnt(input logic [1:0] op, input logic [1:0] vm, input logic [7:0] vpn,
                     input logic [7:0] ppn);
    @(negedge clk);
    mnt_op = op; mnt_vm = vm; mnt_vpn = vpn; mnt_ppn = ppn;
    @(negedge clk);
    mnt_op = 2'b00;
  endtask

  task automatic rb(input logic [1:0] vm, input logic [7:0] vpn,
                    output logic res, output logic dty, output logic [7:0] ppn);
    rb_vm = vm; rb_vpn = vpn;
    #1;
    res = rb_resident; dty = rb_dirty; ppn = rb_ppn;
  endtask

  // One request, response checked one cycle after acceptance
  task automatic xlate(input string tag, input logic [1:0] vm, input logic [15:0] a,
                       input logic st, input logic exp_fault, input logic [15:0] exp_pa);
    @(negedge clk);
    chk({tag, " ready"}, 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_vm = vm; req_addr = a; req_store = st;
    @(negedge clk);
    req_valid = 1'b0; req_store = 1'b0;
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " fault"}, 32'(rsp_fault), 32'(exp_fault));
    chk({tag, " irq"},   32'(irq_fault), 32'(exp_fault));
    chk({tag, " paddr"}, 32'(rsp_paddr), 32'(exp_pa));
  endtask

  task automatic t_reset();
    logic r, d; logic [7:0] p;
    chk("R10 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R10 req_ready", 32'(req_ready), 32'd1);
    rb(2'd0, 8'h00, r, d, p); chk("R10 res e0", 32'(r), 0); chk("R10 dirty e0", 32'(d), 0);
    rb(2'd3, 8'hFF, r, d, p); chk("R10 res elast", 32'(r), 0); chk("R10 dirty elast", 32'(d), 0);
  endtask

  task automatic t_install_hit();
    logic r, d; logic [7:0] p;
    mnt(2'b01, 2'd0, 8'h00, 8'h3C);
    rb(2'd0, 8'h00, r, d, p);
    chk("R5 res", 32'(r), 1); chk("R5 dirty", 32'(d), 0); chk("R5 ppn", 32'(p), 32'h3C);
    xlate("R2 hit", 2'd0, 16'h0017, 1'b0, 1'b0, 16'h3C17);
    mnt(2'b01, 2'd3, 8'hFF, 8'hFF);
    xlate("R1 top corner", 2'd3, 16'hFFFF, 1'b0, 1'b0, 16'hFFFF);
    mnt(2'b01, 2'd2, 8'hA5, 8'h01);
    xlate("R1 split", 2'd2, 16'hA500, 1'b0, 1'b0, 16'h0100);
  endtask

  task automatic t_vm_isolation();
    mnt(2'b01, 2'd1, 8'h00, 8'h81);
    xlate("R9 vm1 page0", 2'd1, 16'h00A5, 1'b0, 1'b0, 16'h81A5);
    xlate("R9 vm0 page0", 2'd0, 16'h00A5, 1'b0, 1'b0, 16'h3CA5);
    xlate("R9 vm2 page0", 2'd2, 16'h00A5, 1'b0, 1'b1, 16'h0000);
  endtask

  task automatic t_fault();
    logic r, d; logic [7:0] p;
    xlate("R3 read fault", 2'd3, 16'h4410, 1'b0, 1'b1, 16'h0000);
    xlate("R3 store fault", 2'd3, 16'h4411, 1'b1, 1'b1, 16'h0000);
    rb(2'd3, 8'h44, r, d, p);
    chk("R3 no res change", 32'(r), 0); chk("R3 no dirty change", 32'(d), 0);
  endtask

  task automatic t_dirty();
    logic r, d; logic [7:0] p;
    xlate("R7 read", 2'd0, 16'h0001, 1'b0, 1'b0, 16'h3C01);
    rb(2'd0, 8'h00, r, d, p); chk("R7 read leaves dirty", 32'(d), 0);
    xlate("R4 store", 2'd0, 16'h0022, 1'b1, 1'b0, 16'h3C22);
    rb(2'd0, 8'h00, r, d, p); chk("R4 dirty set", 32'(d), 1);
    rb(2'd1, 8'h00, r, d, p); chk("R9 other vm clean", 32'(d), 0);
    xlate("R7 read after store", 2'd0, 16'h0003, 1'b0, 1'b0, 16'h3C03);
    rb(2'd0, 8'h00, r, d, p); chk("R7 read keeps dirty", 32'(d), 1);
  endtask

  task automatic t_evict();
    logic r, d; logic [7:0] p;
    mnt(2'b11, 2'd0, 8'h00, 8'h00);
    rb(2'd0, 8'h00, r, d, p); chk("R6 rsvd op no effect", 32'(r), 1);
    mnt(2'b10, 2'd0, 8'h00, 8'h55);
    rb(2'd0, 8'h00, r, d, p);
    chk("R6 evict res", 32'(r), 0); chk("R6 evict keeps dirty", 32'(d), 1);
    chk("R6 evict keeps ppn", 32'(p), 32'h3C);
    xlate("R6 evicted faults", 2'd0, 16'h0010, 1'b0, 1'b1, 16'h0000);
    mnt(2'b01, 2'd0, 8'h00, 8'h42);
    rb(2'd0, 8'h00, r, d, p); chk("R5 reinstall clears dirty", 32'(d), 0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_vm = 2'd1; req_addr = 16'h0011; req_store = 1'b0;
    @(negedge clk);
    chk("R8 first valid", 32'(rsp_valid), 1);
    chk("R8 first paddr", 32'(rsp_paddr), 32'h8111);
    chk("R8 ready low", 32'(req_ready), 0);
    req_vm = 2'd0; req_addr = 16'h0099;
    @(negedge clk);
    @(negedge clk);
    chk("R8 held paddr", 32'(rsp_paddr), 32'h8111);
    chk("R8 held valid", 32'(rsp_valid), 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 second valid", 32'(rsp_valid), 1);
    chk("R8 second paddr", 32'(rsp_paddr), 32'h4299);
    @(negedge clk);
    chk("R8 drained", 32'(rsp_valid), 0);
  endtask

  task automatic t_collision();
    logic r, d; logic [7:0] p;
    mnt(2'b01, 2'd1, 8'h05, 8'h10);
    @(negedge clk);
    req_valid = 1'b1; req_vm = 2'd1; req_addr = 16'h0577; req_store = 1'b1;
    mnt_op = 2'b01; mnt_vm = 2'd1; mnt_vpn = 8'h05; mnt_ppn = 8'h20;
    @(negedge clk);
    req_valid = 1'b0; req_store = 1'b0; mnt_op = 2'b00;
    chk("R11 old ppn used", 32'(rsp_paddr), 32'h1077);
    chk("R11 no fault", 32'(rsp_fault), 0);
    rb(2'd1, 8'h05, r, d, p);
    chk("R11 install wins dirty", 32'(d), 0);
    chk("R11 new ppn", 32'(p), 32'h20);
    xlate("R11 new mapping", 2'd1, 16'h0501, 1'b0, 1'b0, 16'h2001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_install_hit();
    t_vm_isolation();
    t_fault();
    t_dirty();
    t_evict();
    t_backpressure();
    t_collision();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule